// File: doc/BRIEF.md
# Frame Phase Stuffing Controller

Once per line-side transmit frame, the block decides whether that frame carries zero or four stuff bits. It measures how far the line frame start lags the most recent PCM transmit frame start. The measurement is a count of quantizing-clock ticks. Each tick arrives as a one-cycle enable pulse on the system clock.

The count is compared with two programmable limits:

- **Nominal limit.** A lag below it means the line side is running ahead, so four stuff bits are inserted to absorb four line bits of phase. A lag at or above it gives no stuffing.
- **Maximum limit.** A lag at or above it raises a sticky stuffing-error flag, which stays set until software-side logic strobes a clear. The flag does not alter the stuff decision.

The values of the four inserted bits come from a 4-bit pattern input. All results are registered and presented with a one-cycle valid strobe.

Top module: `stuff_ctrl`

## Requirements
- R1: After synchronous reset, `dec_valid`, `stuff_cnt`, `stuff_bits` and `stuff_err` are all 0.
- R2: The measured phase equals the number of `qclk_en` pulses seen in the cycles after the latest `pcm_sof`, up to but not including the `line_sof` cycle. It saturates at 2^CNT_W-1 instead of wrapping.
- R3: If the measured phase is below `thr_nom`, the decision is `stuff_cnt` = 4 and `stuff_bits` = `stuff_pat` as sampled in the `line_sof` cycle.
- R4: If the measured phase is at or above `thr_nom`, the decision is `stuff_cnt` = 0 and `stuff_bits` = 0.
- R5: `dec_valid` is high for exactly the one cycle after each `line_sof` cycle and low otherwise.
- R6: A measured phase at or above `thr_max` sets `stuff_err`, visible together with that frame's `dec_valid`. `stuff_err` then stays set while `err_clr` is low.
- R7: `err_clr` clears `stuff_err` one cycle later, unless a new error is detected in the same cycle, in which case the flag stays set.
- R8: The error flag has no effect on the stuff decision: with `thr_max` below `thr_nom`, a phase between them gives both `stuff_err` = 1 and `stuff_cnt` = 4.
- R9: When `pcm_sof` and `line_sof` are high in the same cycle, the measured phase is 0.
- R10: Between decisions, `stuff_cnt` and `stuff_bits` hold their last values regardless of `qclk_en` activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| qclk_en | input | 1 | Quantizing-clock tick, one cycle wide |
| pcm_sof | input | 1 | PCM transmit frame start pulse |
| line_sof | input | 1 | Line transmit frame start pulse |
| thr_nom | input | CNT_W | Nominal phase limit |
| thr_max | input | CNT_W | Maximum phase limit |
| stuff_pat | input | 4 | Values for inserted stuff bits |
| err_clr | input | 1 | Clear strobe for the error flag |
| dec_valid | output | 1 | Decision valid strobe |
| stuff_cnt | output | 3 | Stuff bits for this frame (0 or 4) |
| stuff_bits | output | 4 | Stuff bit values (0 when none inserted) |
| stuff_err | output | 1 | Sticky stuffing-error flag |

## Verification
The bench builds the block with CNT_W = 6. This makes the saturation point of 63 reachable within a short frame, and a run of 70 ticks can be told apart from a wrapped count of 6. Thresholds of 16 and 24 ticks, which correspond to 16 and 24 line bits at one tick per bit, exercise the exact-boundary cases. Dense and sparse tick spacing both appear, and swapped limits separate the error flag from the decision.

// File: rtl/stuff_pkg.sv
`timescale 1ns/1ps
package stuff_pkg;
  localparam int STUFF_BITS = 4;
  localparam int SCNT_W     = $clog2(STUFF_BITS + 1);
  typedef logic [SCNT_W-1:0]     scnt_t;
  typedef logic [STUFF_BITS-1:0] spat_t;
  localparam scnt_t SCNT_NONE = '0;
  localparam scnt_t SCNT_FULL = scnt_t'(STUFF_BITS);
endpackage

// File: rtl/phase_meter.sv
`timescale 1ns/1ps
// Counts quantizing ticks since the latest PCM frame start; saturating.
module phase_meter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pcm_sof,
  input  logic             qclk_en,
  output logic [CNT_W-1:0] phase
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                           cnt_q <= '0;
    else if (pcm_sof)                  cnt_q <= '0;
    else if (qclk_en && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  // A PCM start in the measuring cycle means zero lag.
  assign phase = pcm_sof ? '0 : cnt_q;

  a_r2_saturate: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && !pcm_sof) |=> cnt_q == CNT_MAX);
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!qclk_en && !pcm_sof) |=> $stable(cnt_q));
  a_r2_restart: assert property (@(posedge clk) disable iff (rst)
    pcm_sof |=> cnt_q == '0);
endmodule

// File: rtl/stuff_decide.sv
`timescale 1ns/1ps
// Registers the per-frame stuff decision at the line frame start.
module stuff_decide
  import stuff_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_sof,
  input  logic [CNT_W-1:0] phase,
  input  logic [CNT_W-1:0] thr_nom,
  input  logic [CNT_W-1:0] thr_max,
  input  spat_t            stuff_pat,
  output logic             dec_valid,
  output scnt_t            stuff_cnt,
  output spat_t            stuff_bits,
  output logic             over_max
);
  logic need_stuff;
  assign need_stuff = phase < thr_nom;
  assign over_max   = line_sof && (phase >= thr_max);

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      stuff_cnt  <= SCNT_NONE;
      stuff_bits <= '0;
    end else begin
      dec_valid <= line_sof;
      if (line_sof) begin
        stuff_cnt  <= need_stuff ? SCNT_FULL : SCNT_NONE;
        stuff_bits <= need_stuff ? stuff_pat : '0;
      end
    end
  end

  a_r5_valid_follows: assert property (@(posedge clk) disable iff (rst)
    line_sof |=> dec_valid);
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !line_sof |=> !dec_valid);
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !line_sof |=> ($stable(stuff_cnt) && $stable(stuff_bits)));
  a_r4_zero_bits: assert property (@(posedge clk) disable iff (rst)
    (stuff_cnt == SCNT_NONE) |-> stuff_bits == '0);
  a_r3_legal_cnt: assert property (@(posedge clk) disable iff (rst)
    (stuff_cnt == SCNT_NONE) || (stuff_cnt == SCNT_FULL));
endmodule

// File: rtl/err_flag.sv
`timescale 1ns/1ps
// Sticky error flag; a new set wins over a clear in the same cycle.
module err_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
  a_r6_set: assert property (@(posedge clk) disable iff (rst)
    set |=> flag);
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !flag);
endmodule

// File: rtl/stuff_ctrl.sv
`timescale 1ns/1ps
module stuff_ctrl
  import stuff_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             qclk_en,
  input  logic             pcm_sof,
  input  logic             line_sof,
  input  logic [CNT_W-1:0] thr_nom,
  input  logic [CNT_W-1:0] thr_max,
  input  logic [3:0]       stuff_pat,
  input  logic             err_clr,
  output logic             dec_valid,
  output logic [2:0]       stuff_cnt,
  output logic [3:0]       stuff_bits,
  output logic             stuff_err
);
  logic [CNT_W-1:0] phase;
  logic             over_max;

  phase_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst(rst), .pcm_sof(pcm_sof), .qclk_en(qclk_en), .phase(phase)
  );

  stuff_decide #(.CNT_W(CNT_W)) u_decide (
    .clk(clk), .rst(rst), .line_sof(line_sof), .phase(phase),
    .thr_nom(thr_nom), .thr_max(thr_max), .stuff_pat(stuff_pat),
    .dec_valid(dec_valid), .stuff_cnt(stuff_cnt), .stuff_bits(stuff_bits),
    .over_max(over_max)
  );

  err_flag u_err (
    .clk(clk), .rst(rst), .set(over_max), .clr(err_clr), .flag(stuff_err)
  );

  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!dec_valid && stuff_cnt == 3'd0 && !stuff_err));
endmodule

// File: tb/test_stuff_ctrl.sv
`timescale 1ns/1ps
module test_stuff_ctrl;
  localparam int CNT_W = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic qclk_en = 0, pcm_sof = 0, line_sof = 0, err_clr = 0;
  logic [CNT_W-1:0] thr_nom = 6'd16, thr_max = 6'd24;
  logic [3:0] stuff_pat = 4'b1010;
  logic dec_valid, stuff_err;
  logic [2:0] stuff_cnt;
  logic [3:0] stuff_bits;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stuff_ctrl #(.CNT_W(CNT_W)) i_stuff_ctrl (
    .clk(clk), .rst(rst), .qclk_en(qclk_en), .pcm_sof(pcm_sof),
    .line_sof(line_sof), .thr_nom(thr_nom), .thr_max(thr_max),
    .stuff_pat(stuff_pat), .err_clr(err_clr), .dec_valid(dec_valid),
    .stuff_cnt(stuff_cnt), .stuff_bits(stuff_bits), .stuff_err(stuff_err)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // PCM start, n ticks with gap idle cycles between them, then a line start.
  // On return the decision cycle is being sampled.
  task automatic run_frame(input int n, input int gap, input bit clr);
    pcm_sof = 1; @(negedge clk); pcm_sof = 0;
    for (int i = 0; i < n; i++) begin
      qclk_en = 1; @(negedge clk); qclk_en = 0;
      repeat (gap) @(negedge clk);
    end
    line_sof = 1; err_clr = clr; @(negedge clk);
    line_sof = 0; err_clr = 0;
  endtask

  task automatic expect_dec(input string req, input int cnt, input int err);
    check(req, "dec_valid", dec_valid, 1);
    check(req, "stuff_cnt", stuff_cnt, cnt);
    check(req, "stuff_bits", stuff_bits, (cnt == 4) ? stuff_pat : 0);
    check(req, "stuff_err", stuff_err, err);
  endtask

  task automatic t_reset();
    check("R1", "dec_valid", dec_valid, 0);
    check("R1", "stuff_cnt", stuff_cnt, 0);
    check("R1", "stuff_bits", stuff_bits, 0);
    check("R1", "stuff_err", stuff_err, 0);
  endtask

  task automatic t_below_nom();
    run_frame(10, 0, 0); expect_dec("R3", 4, 0);
    @(negedge clk); check("R5", "dec_valid low after pulse", dec_valid, 0);
    stuff_pat = 4'b0110;
    run_frame(15, 2, 0); expect_dec("R2 sparse R3", 4, 0);
  endtask

  task automatic t_at_nom();
    run_frame(16, 0, 0); expect_dec("R4 at nominal", 0, 0);
    run_frame(20, 1, 0); expect_dec("R4 above nominal", 0, 0);
  endtask

  task automatic t_error();
    run_frame(23, 0, 0); expect_dec("R6 below max", 0, 0);
    run_frame(24, 0, 0); expect_dec("R6 at max", 0, 1);
    run_frame(5, 0, 0);  expect_dec("R6 sticky", 4, 1);
    err_clr = 1; @(negedge clk); err_clr = 0;
    check("R7", "stuff_err cleared", stuff_err, 0);
    run_frame(30, 0, 1); expect_dec("R7 set wins over clear", 0, 1);
    err_clr = 1; @(negedge clk); err_clr = 0;
  endtask

  task automatic t_saturate();
    thr_nom = 6'd63; thr_max = 6'd63;
    run_frame(70, 0, 0); expect_dec("R2 saturates", 0, 1);
    err_clr = 1; @(negedge clk); err_clr = 0;
    run_frame(62, 0, 0); expect_dec("R2 count 62", 4, 0);
  endtask

  task automatic t_independent();
    thr_nom = 6'd40; thr_max = 6'd10;
    run_frame(20, 0, 0); expect_dec("R8", 4, 1);
    err_clr = 1; @(negedge clk); err_clr = 0;
    thr_nom = 6'd16; thr_max = 6'd24;
  endtask

  task automatic t_same_cycle();
    pcm_sof = 1; @(negedge clk); pcm_sof = 0;
    qclk_en = 1; repeat (30) @(negedge clk); qclk_en = 0;
    pcm_sof = 1; line_sof = 1; @(negedge clk);
    pcm_sof = 0; line_sof = 0;
    expect_dec("R9", 4, 0);
  endtask

  task automatic t_hold();
    run_frame(18, 0, 0); expect_dec("R10 setup", 0, 0);
    for (int i = 0; i < 20; i++) begin
      qclk_en = i[0];
      @(negedge clk);
      check("R10", "stuff_cnt held", stuff_cnt, 0);
      check("R5", "dec_valid idle", dec_valid, 0);
    end
    qclk_en = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_below_nom();
    t_at_nom();
    t_error();
    t_saturate();
    t_independent();
    t_same_cycle();
    t_hold();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule